// File: doc/BRIEF.md
# GPIO Controller with Interrupt Sensing

A register-mapped controller for 32 general-purpose pins. Every pin is set up on its own, either as a plain input/output or as an interrupt source. In plain mode a direction bit decides whether the pin is driven from an output-data register. The input-data register always returns the pin levels after a two-flop synchronizer.

In interrupt mode, three independent per-pin bits select the trigger: polarity, edge versus level, and both-edge. Edge events are latched in a pending bit until software writes a one to the clear register. A level-sensed pin shows its polarity-adjusted level as pending for as long as that level is present. Enables are changed through two write-only-style ports: one sets enables, the other clears them. No read-modify-write is needed. A single request output is the OR of every pending and enabled pin.

The bus is a 32-bit single-cycle port. A write takes effect at the clock edge on which `bus_en_i` and `bus_we_i` are high. Read data is combinational from `bus_addr_i`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset all pins are plain inputs (`pin_oe_o` = 0, `pin_o` = 0), every enable is 0, every pending bit is 0, polarity is 0 (active-high/rising) and every pin is level-sensed. `irq_o` is 0.
- R2: `pin_oe_o[i]` is 1 only when direction bit i (offset 0x04, 1 = output) is 1 and mode bit i (offset 0x00, 1 = interrupt input) is 0. `pin_o[i]` carries output-data bit i (offset 0x08) while the pin is enabled as an output, and is 0 otherwise.
- R3: The input-data register (offset 0x0C, read-only) returns pin levels through two register stages. A pin change is not yet visible one clock edge after it occurs, and is visible from the second edge on.
- R4: A level-sensed interrupt pin (edge bit at 0x24 = 0) is pending while its synchronized level XOR its polarity bit (0x20) is 1. A write to the clear register does not remove it.
- R5: An edge-sensed pin (edge bit = 1) with polarity 0 and both-edge bit (0x4C) 0 latches pending on a 0-to-1 transition. The bit stays set after the pin returns low.
- R6: With polarity 1 the edge-sensed pin latches only on 1-to-0 transitions and ignores rising ones.
- R7: With the both-edge bit set, rising and falling transitions both latch pending, whatever the polarity bit holds.
- R8: Writing the clear register (offset 0x14) clears each edge pending bit whose write bit is 1. Bits written 0 leave pending unchanged. Pending is read at offset 0x10.
- R9: Writing 1 to a bit of the enable-set register (0x1C) enables that pin. Writing 0 to a bit of the mask register (0x18) disables that pin, and a 1 there leaves it unchanged. Both offsets read back the enable vector (1 = enabled).
- R10: `irq_o` is the OR over all pins of pending AND enabled. A pin whose mode bit is 0 is never pending, and a latched edge is dropped when the pin leaves interrupt mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| pin_i | input | 32 | Raw pin levels |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest states to reach are those where a latched edge must outlive its cause. A pending bit has to stay set after the pin returns to its idle level. It must also survive a clear write with zero bits, and it must be dropped when the pin leaves interrupt mode. The stimulus reaches these by moving the pin through a full pulse while sense bits hold steady, then writing the clear, mask and mode registers one at a time. Between writes it reads pending and samples `irq_o`. The polarity bit is set opposite to the transition under test on the both-edge pin, which shows that polarity no longer filters edges there.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMSK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EDGE  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 8'h4C;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  mode_o,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  dout_o,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  edge_o,
  output logic [NPINS-1:0]  both_o,
  output logic [NPINS-1:0]  clr_o
);
  logic [NPINS-1:0] mode_q, dir_q, dout_q, en_q, pol_q, edge_q, both_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      edge_q <= '0;
      both_q <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        OFS_MODE:  mode_q <= wdata_i;
        OFS_DIR:   dir_q  <= wdata_i;
        OFS_DOUT:  dout_q <= wdata_i;
        OFS_MASK:  en_q   <= en_q & wdata_i;   // zero bits disable
        OFS_UNMSK: en_q   <= en_q | wdata_i;   // one bits enable
        OFS_POL:   pol_q  <= wdata_i;
        OFS_EDGE:  edge_q <= wdata_i;
        OFS_BOTH:  both_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o  = (wr_i && addr_i == OFS_CLR) ? wdata_i : '0;
  assign mode_o = mode_q;
  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign edge_o = edge_q;
  assign both_o = both_q;
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic [NPINS-1:0] edge_i,
  input  logic [NPINS-1:0] both_i,
  input  logic [NPINS-1:0] clr_i,
  output logic [NPINS-1:0] pend_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, hit, armed, latch_q;

    assign rise  = lvl_i[i] & ~prev_q[i];
    assign fall  = ~lvl_i[i] & prev_q[i];
    assign hit   = both_i[i] ? (rise | fall) : (pol_i[i] ? fall : rise);
    assign armed = mode_i[i] & edge_i[i];

    // a new event wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       latch_q <= 1'b0;
      else if (!armed)   latch_q <= 1'b0;
      else if (hit)      latch_q <= 1'b1;
      else if (clr_i[i]) latch_q <= 1'b0;
    end

    assign pend_o[i] = mode_i[i] & (edge_i[i] ? latch_q : (lvl_i[i] ^ pol_i[i]));
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic             wr;
  logic [NPINS-1:0] lvl, mode_q, dir_q, dout_q, en_q, pol_q, edge_q, both_q, clr, pend;

  assign wr = bus_en_i & bus_we_i;

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  gpio_cfg_regs #(.NPINS(NPINS)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .addr_i (bus_addr_i),
    .wdata_i(bus_wdata_i[NPINS-1:0]),
    .mode_o (mode_q),
    .dir_o  (dir_q),
    .dout_o (dout_q),
    .en_o   (en_q),
    .pol_o  (pol_q),
    .edge_o (edge_q),
    .both_o (both_q),
    .clr_o  (clr)
  );

  gpio_irq_sense #(.NPINS(NPINS)) u_sense (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .mode_i(mode_q),
    .pol_i (pol_q),
    .edge_i(edge_q),
    .both_i(both_q),
    .clr_i (clr),
    .pend_o(pend)
  );

  assign pin_oe_o = dir_q & ~mode_q;
  assign pin_o    = dout_q & pin_oe_o;
  assign irq_o    = |(pend & en_q);

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_MODE:            bus_rdata_o = DATA_W'(mode_q);
      OFS_DIR:             bus_rdata_o = DATA_W'(dir_q);
      OFS_DOUT:            bus_rdata_o = DATA_W'(dout_q);
      OFS_DIN:             bus_rdata_o = DATA_W'(lvl);
      OFS_PEND:            bus_rdata_o = DATA_W'(pend);
      OFS_MASK, OFS_UNMSK: bus_rdata_o = DATA_W'(en_q);
      OFS_POL:             bus_rdata_o = DATA_W'(pol_q);
      OFS_EDGE:            bus_rdata_o = DATA_W'(edge_q);
      OFS_BOTH:            bus_rdata_o = DATA_W'(both_q);
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_en_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  en_q,
  input logic [NPINS-1:0]  pend
);
  logic wr_unmask, wr_mask;
  assign wr_unmask = bus_en_i && bus_we_i && bus_addr_i == OFS_UNMSK;
  assign wr_mask   = bus_en_i && bus_we_i && bus_addr_i == OFS_MASK;

  assert_oe_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & mode_q) == '0);

  assert_gpio_never_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend & ~mode_q) == '0);

  assert_irq_needs_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_q != '0));

  assert_unmask_sets_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_unmask |=> ((en_q & $past(bus_wdata_i[NPINS-1:0])) == $past(bus_wdata_i[NPINS-1:0])));

  assert_mask_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> ((en_q & ~$past(bus_wdata_i[NPINS-1:0])) == '0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_en_i   (bus_en_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .pin_oe_o   (pin_oe_o),
  .irq_o      (irq_o),
  .mode_q     (mode_q),
  .en_q       (en_q),
  .pend       (pend)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef enum logic [1:0] {K_NONE, K_RD, K_IRQ, K_OE} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] pins = '0, pin_out, pin_oe;
  logic        irq;
  kind_e       probe = K_NONE;
  item_t       sb_q[$];
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_i(pins), .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // monitor: pops expectations and compares away from the active edge
  always @(negedge clk) begin
    if (probe != K_NONE) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = rdata;
        K_IRQ:   act = {31'd0, irq};
        K_OE:    act = pin_oe;
        default: act = pin_out;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    en = 1'b1; we = 1'b0; addr = a;
    sb_q.push_back('{K_RD, e, tag});
    probe = K_RD;
    @(posedge clk); #1;
    en = 1'b0; probe = K_NONE;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(posedge clk); #1;
    sb_q.push_back('{K_IRQ, {31'd0, e}, tag});
    probe = K_IRQ;
    @(posedge clk); #1;
    probe = K_NONE;
  endtask

  task automatic chk_pins(input logic [31:0] oe, input logic [31:0] po, input string tag);
    @(posedge clk); #1;
    sb_q.push_back('{K_OE, oe, tag});
    probe = K_OE;
    @(posedge clk); #1;
    sb_q.push_back('{K_NONE, po, tag});
    probe = K_NONE;
    probe = kind_e'(2'd3);
    @(posedge clk); #1;
    probe = K_NONE;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(posedge clk); #1;
    pins = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(8'h00, 32'h0, "R1 mode");
    rd(8'h10, 32'h0, "R1 pending");
    rd(8'h18, 32'h0, "R1 enables");
    rd(8'h20, 32'h0, "R1 polarity");
    rd(8'h24, 32'h0, "R1 edge select");
    chk_pins(32'h0, 32'h0, "R1 pins");
    chk_irq(1'b0, "R1 irq");

    // R2: output path
    wr(8'h08, 32'hA5A5_0F0F);
    wr(8'h04, 32'h0000_FFFF);
    chk_pins(32'h0000_FFFF, 32'h0000_0F0F, "R2 outputs");
    wr(8'h00, 32'h0000_0001);
    chk_pins(32'h0000_FFFE, 32'h0000_0F0E, "R2 intr mode gates oe");
    rd(8'h08, 32'hA5A5_0F0F, "R2 dout readback");

    // R3: input sampling, R10 plain pins never pending
    set_pins(32'h1234_5678);
    rd(8'h0C, 32'h1234_5678, "R3 din");
    rd(8'h10, 32'h0, "R10 plain pins not pending");
    @(posedge clk); #1 pins = 32'h0000_0002;
    rd(8'h0C, 32'h1234_5678, "R3 one-edge delay");
    rd(8'h0C, 32'h0000_0002, "R3 after two edges");
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    set_pins(32'h0);

    // R4: level high on pin 4
    wr(8'h00, 32'h0000_0010);
    set_pins(32'h0000_0010);
    rd(8'h10, 32'h0000_0010, "R4 level high pending");
    chk_irq(1'b0, "R9 masked after reset");
    wr(8'h1C, 32'h0000_0010);
    chk_irq(1'b1, "R10 irq asserted");
    wr(8'h14, 32'h0000_0010);
    rd(8'h10, 32'h0000_0010, "R4 clear ignored on level");
    set_pins(32'h0);
    rd(8'h10, 32'h0, "R4 level gone");
    chk_irq(1'b0, "R10 irq dropped");

    // R4: level low on pin 5
    wr(8'h20, 32'h0000_0020);
    wr(8'h00, 32'h0000_0030);
    rd(8'h10, 32'h0000_0020, "R4 level low pending");
    set_pins(32'h0000_0020);
    rd(8'h10, 32'h0, "R4 level low released");

    // R5: rising edge on pin 8
    wr(8'h24, 32'h0000_0100);
    wr(8'h00, 32'h0000_0130);
    set_pins(32'h0000_0120);
    rd(8'h10, 32'h0000_0100, "R5 rising latched");
    set_pins(32'h0000_0020);
    rd(8'h10, 32'h0000_0100, "R5 held after pin low");
    wr(8'h14, 32'h0);
    rd(8'h10, 32'h0000_0100, "R8 zero clear no effect");
    wr(8'h14, 32'h0000_0100);
    rd(8'h10, 32'h0, "R8 one clears");

    // R6: falling edge on pin 9
    wr(8'h20, 32'h0000_0220);
    wr(8'h24, 32'h0000_0300);
    wr(8'h00, 32'h0000_0330);
    set_pins(32'h0000_0220);
    rd(8'h10, 32'h0, "R6 rising ignored");
    set_pins(32'h0000_0020);
    rd(8'h10, 32'h0000_0200, "R6 falling latched");
    wr(8'h14, 32'h0000_0200);

    // R7: both edges on pin 10, polarity set
    wr(8'h20, 32'h0000_0620);
    wr(8'h24, 32'h0000_0700);
    wr(8'h4C, 32'h0000_0400);
    wr(8'h00, 32'h0000_0730);
    set_pins(32'h0000_0420);
    rd(8'h10, 32'h0000_0400, "R7 rising latched");
    wr(8'h14, 32'h0000_0400);
    rd(8'h10, 32'h0, "R8 clear both-edge");
    set_pins(32'h0000_0020);
    rd(8'h10, 32'h0000_0400, "R7 falling latched");

    // R9: enable set / mask clear
    wr(8'h1C, 32'h0000_0400);
    rd(8'h18, 32'h0000_0410, "R9 unmask readback");
    chk_irq(1'b1, "R10 irq from edge");
    wr(8'h18, 32'hFFFF_FBFF);
    rd(8'h1C, 32'h0000_0010, "R9 zero masks one pin");
    chk_irq(1'b0, "R9 masked irq");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, 32'h0000_0010, "R9 ones leave enables");

    // R10: leaving interrupt mode drops the latch
    wr(8'h1C, 32'h0000_0400);
    wr(8'h00, 32'h0000_0330);
    rd(8'h10, 32'h0, "R10 latch dropped on mode exit");
    chk_irq(1'b0, "R10 irq off after mode exit");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule